// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block decides when an analog-to-digital conversion may begin and reports how far each conversion has progressed. Software sets a mode register that chooses between software-started and pin-started conversions, the active edge of an asynchronous trigger pin, and whether pin edges need software to arm the block first. A write of any value to a start register either starts a conversion directly or only arms the block for the next qualifying pin edge.

Each conversion moves through three stages: armed, triggered (covering an optional programmable wait), and converting. Each stage has its own read-only status flag. After the wait the block gives a one-cycle start pulse to the converter and then waits for the converter's done input. All flags are cleared when the done input arrives. Trigger events that come while a conversion is pending or running are dropped.

Top module: `adc_trig_ctl`

## Requirements
- R1: After reset, the mode register, the wait register and all three status flags read zero and `soc_out` is low. This gives software-started, rising-edge, non-automatic operation.
- R2: The register map is: address 0 mode, 1 start (write-only, reads 0), 2 status, 3 wait count. In the mode register, bit 0 selects the active pin edge, bit 1 selects pin triggering and bit 2 enables automatic mode. Bits above 2 always read zero.
- R3: The status register has armed in bit 0, triggered in bit 1 and converting in bit 2. Converting is set only while triggered is also set.
- R4: With bit 1 of the mode register at 0, a start write both arms and triggers a conversion. Bit 2 and the trigger pin then have no effect.
- R5: With bit 1 at 1 and bit 2 at 0, a start write only arms the block. The arming is kept until a qualifying pin edge uses it. Pin edges are ignored while the block is not armed.
- R6: With bits 1 and 2 both at 1, every qualifying pin edge triggers a conversion without arming.
- R7: With bit 0 at 0 a rising pin edge qualifies; with bit 0 at 1 a falling edge qualifies.
- R8: Let D be the wait count. After a start write is accepted at a clock edge, `soc_out` is high D cycles later. A pin change is taken as a trigger on the third rising clock edge after it, so the start comes D+2 cycles after the first edge. Converting sets on the clock edge after the start pulse.
- R9: `soc_out` is a single-cycle pulse, and it comes once per conversion.
- R10: A done input while converting clears all three flags. A done input at any other time has no effect.
- R11: Start writes and pin edges that arrive while triggered is set are discarded and are not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| async_trig_in | input | 1 | Asynchronous external trigger pin |
| conv_done_in | input | 1 | Converter reports end of conversion |
| soc_out | output | 1 | One-cycle start-of-conversion pulse |

## Verification
The bench builds the block with a 4-bit wait counter, a 16-bit data bus and a 2-bit address. The narrow counter makes the largest wait of 15 cycles cheap to reach, so the zero wait and the maximum wait are both measured against the expected latency. A vector table walks every mode combination with both edge polarities, with armed and unarmed pin edges, and with an arming that is left over from one vector for the next. Directed tests then cover the reset values, the reserved bits, discarded triggers during the wait and during conversion, and done inputs that arrive while idle.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

    // mode register fields, bit 2 down to bit 0
    typedef struct packed {
        logic auto_mode;
        logic pin_sel;
        logic fall_pol;
    } mode_t;

    // status flags, bit 2 down to bit 0
    typedef struct packed {
        logic converting;
        logic triggered;
        logic armed;
    } stat_t;

    localparam int REG_MODE  = 0;
    localparam int REG_START = 1;
    localparam int REG_STAT  = 2;
    localparam int REG_WAIT  = 3;

    function automatic logic edge_hit(logic cur, logic prev, logic fall);
        return fall ? (prev & ~cur) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/adc_trig_sync_edge.sv
module adc_trig_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall,
    output logic hit
);
    import adc_trig_pkg::*;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign hit = edge_hit(chain_q[SYNC_STAGES-1], prev_q, fall);

endmodule

// File: rtl/adc_trig_delay.sv
module adc_trig_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             count_en,
    output logic             expired
);
    logic [DLY_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)                       cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (count_en && !expired) cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
    import adc_trig_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_sel,
    input  logic  auto_mode,
    input  logic  start_wr,
    input  logic  pin_hit,
    input  logic  dly_expired,
    input  logic  conv_done,
    output stat_t stat,
    output logic  dly_load,
    output logic  dly_run,
    output logic  soc
);
    seq_state_e state_q;
    logic       armed_q;
    logic       busy;
    logic       trig_ev;
    logic       finish;

    assign busy    = (state_q != ST_IDLE);
    assign trig_ev = !busy && (pin_sel ? (pin_hit && (auto_mode || armed_q)) : start_wr);
    assign finish  = (state_q == ST_CONV) && conv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (trig_ev)     state_q <= ST_WAIT;
                ST_WAIT: if (dly_expired) state_q <= ST_CONV;
                ST_CONV: if (conv_done)   state_q <= ST_IDLE;
                default:                  state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   armed_q <= 1'b0;
        else if (finish)           armed_q <= 1'b0;
        else if (start_wr && !busy) armed_q <= 1'b1;
    end

    assign dly_load        = trig_ev;
    assign dly_run         = (state_q == ST_WAIT);
    assign soc             = (state_q == ST_WAIT) && dly_expired;
    assign stat.armed      = armed_q;
    assign stat.triggered  = busy;
    assign stat.converting = (state_q == ST_CONV);

endmodule

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl
    import adc_trig_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 16,
    parameter int DLY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              async_trig_in,
    input  logic              conv_done_in,
    output logic              soc_out
);
    localparam int MODE_W = $bits(mode_t);
    localparam int STAT_W = $bits(stat_t);

    mode_t            mode_q;
    logic [DLY_W-1:0] wait_q;
    stat_t            stat;
    logic [2:0]       stat_w;
    logic             start_wr;
    logic             pin_hit;
    logic             dly_load;
    logic             dly_run;
    logic             dly_expired;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign start_wr     = bus_wr && (bus_addr == ADDR_W'(REG_START));
    assign stat_w       = stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            wait_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(REG_MODE)) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
            if (bus_addr == ADDR_W'(REG_WAIT)) wait_q <= bus_wdata[DLY_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_MODE)) bus_rdata[MODE_W-1:0] = mode_q;
        if (bus_addr == ADDR_W'(REG_STAT)) bus_rdata[STAT_W-1:0] = stat;
        if (bus_addr == ADDR_W'(REG_WAIT)) bus_rdata[DLY_W-1:0]  = wait_q;
    end

    adc_trig_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (async_trig_in),
        .fall (mode_q.fall_pol),
        .hit  (pin_hit)
    );

    adc_trig_delay #(.DLY_W(DLY_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (wait_q),
        .count_en (dly_run),
        .expired  (dly_expired)
    );

    adc_trig_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .pin_sel     (mode_q.pin_sel),
        .auto_mode   (mode_q.auto_mode),
        .start_wr    (start_wr),
        .pin_hit     (pin_hit),
        .dly_expired (dly_expired),
        .conv_done   (conv_done_in),
        .stat        (stat),
        .dly_load    (dly_load),
        .dly_run     (dly_run),
        .soc         (soc_out)
    );

endmodule

// File: rtl/adc_trig_ctl_chk.sv
module adc_trig_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       soc,
    input logic [2:0] stat,
    input logic       pin_sel,
    input logic       auto_mode,
    input logic       conv_done,
    input logic       start_wr
);
    // R9: start pulse lasts one cycle
    assert_soc_single_R9: assert property (@(posedge clk) disable iff (rst)
        soc |=> !soc);

    // R8: start pulse only while triggered and not yet converting
    assert_soc_in_wait_R8: assert property (@(posedge clk) disable iff (rst)
        soc |-> (stat[1] && !stat[2]));

    // R8: converting rises only right after a start pulse
    assert_conv_after_soc_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[2]) |-> $past(soc));

    // R3: converting implies triggered
    assert_conv_has_trig_R3: assert property (@(posedge clk) disable iff (rst)
        stat[2] |-> stat[1]);

    // R10: done while converting clears every flag
    assert_done_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (stat[2] && conv_done) |=> (stat == 3'b000));

    // R5: in non-automatic pin mode a trigger needs prior arming
    assert_arm_gate_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat[1]) && $past(pin_sel && !auto_mode)) |-> $past(stat[0]));

    // R4: in software mode a trigger comes from a start write
    assert_sw_trigger_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat[1]) && $past(!pin_sel)) |-> $past(start_wr));

endmodule

bind adc_trig_ctl adc_trig_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .soc       (soc_out),
    .stat      (stat_w),
    .pin_sel   (mode_q.pin_sel),
    .auto_mode (mode_q.auto_mode),
    .conv_done (conv_done_in),
    .start_wr  (start_wr)
);

// File: tb/adc_trig_ctl_tb.sv
`timescale 1ns/1ps
module adc_trig_ctl_tb;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;
    localparam int DLY_W  = 4;

    typedef struct packed {
        logic [2:0] mode;
        logic [3:0] dly;
        logic [1:0] act;   // 0 start write, 1 pin edge, 2 start write then pin edge
        logic       fire;
        logic [4:0] lat;
        logic [2:0] after;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 4'd0,  2'd0, 1'b1, 5'd0,  3'b000},
        '{3'b000, 4'd3,  2'd0, 1'b1, 5'd3,  3'b000},
        '{3'b100, 4'd2,  2'd0, 1'b1, 5'd2,  3'b000},
        '{3'b010, 4'd0,  2'd1, 1'b0, 5'd0,  3'b000},
        '{3'b010, 4'd1,  2'd2, 1'b1, 5'd3,  3'b000},
        '{3'b110, 4'd0,  2'd1, 1'b1, 5'd2,  3'b000},
        '{3'b111, 4'd4,  2'd1, 1'b1, 5'd6,  3'b000},
        '{3'b011, 4'd0,  2'd2, 1'b1, 5'd2,  3'b000},
        '{3'b011, 4'd0,  2'd1, 1'b0, 5'd0,  3'b000},
        '{3'b000, 4'd0,  2'd1, 1'b0, 5'd0,  3'b000},
        '{3'b010, 4'd0,  2'd0, 1'b0, 5'd0,  3'b001},
        '{3'b010, 4'd0,  2'd1, 1'b1, 5'd2,  3'b000},
        '{3'b110, 4'd15, 2'd1, 1'b1, 5'd17, 3'b000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              async_trig_in = 1'b0;
    logic              conv_done_in = 1'b0;
    logic              soc_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adc_trig_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .async_trig_in (async_trig_in),
        .conv_done_in  (conv_done_in),
        .soc_out       (soc_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr  = ADDR_W'(a);
        bus_wdata = DATA_W'(d);
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = ADDR_W'(a);
        #0.5;
        d = int'(bus_rdata);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        conv_done_in = 1'b1;
        @(negedge clk);
        conv_done_in = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        int socs;
        int lat;
        bit fired;

        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset values
        rd(0, v); check(v == 0, "R1 mode", v, 0);
        rd(2, v); check(v == 0, "R1 status", v, 0);
        rd(3, v); check(v == 0, "R1 wait", v, 0);
        check(soc_out == 1'b0, "R1 soc", int'(soc_out), 0);

        // R2: reserved bits and write-only start address
        wr(0, 16'hFFFF);
        rd(0, v); check(v == 7, "R2 reserved bits", v, 7);
        wr(0, 0);
        rd(1, v); check(v == 0, "R2 start reads zero", v, 0);

        // table walk: R3..R8
        for (int k = 0; k < NV; k++) begin
            wr(0, 0);
            @(negedge clk);
            async_trig_in = VECS[k].mode[0];
            idle(4);
            wr(3, int'(VECS[k].dly));
            wr(0, int'(VECS[k].mode));
            @(negedge clk);
            if (VECS[k].act == 2'd1) begin
                async_trig_in = ~VECS[k].mode[0];
            end else begin
                bus_addr  = ADDR_W'(1);
                bus_wdata = 16'h5A5A;
                bus_wr    = 1'b1;
                if (VECS[k].act == 2'd2) begin
                    @(negedge clk);
                    bus_wr = 1'b0;
                    async_trig_in = ~VECS[k].mode[0];
                end
            end
            fired = 1'b0; lat = 0; socs = 0;
            for (int n = 0; n < 25; n++) begin
                @(negedge clk);
                bus_wr = 1'b0;
                if (soc_out) begin
                    socs++;
                    if (!fired) begin fired = 1'b1; lat = n; end
                end
            end
            check(fired == VECS[k].fire, $sformatf("R4/R5/R6/R7 fire v%0d", k),
                  int'(fired), int'(VECS[k].fire));
            check(socs <= 1, $sformatf("R9 soc count v%0d", k), socs, 1);
            if (VECS[k].fire) begin
                check(lat == int'(VECS[k].lat), $sformatf("R8 latency v%0d", k),
                      lat, int'(VECS[k].lat));
                rd(2, v);
                check((v & 6) == 6, $sformatf("R3 converting v%0d", k), v & 6, 6);
                done_pulse();
            end
            rd(2, v);
            check(v == int'(VECS[k].after), $sformatf("R10 status after v%0d", k),
                  v, int'(VECS[k].after));
        end

        // R11: second start write during the wait is discarded
        wr(0, 0);
        @(negedge clk);
        async_trig_in = 1'b0;
        idle(4);
        wr(3, 5);
        wr(1, 1);
        socs = 0;
        wr(1, 1);
        for (int n = 0; n < 12; n++) begin
            if (soc_out) socs++;
            @(negedge clk);
        end
        check(socs == 1, "R11 one start during wait", socs, 1);
        // R11: start write and pin edge during conversion are discarded
        wr(1, 1);
        wr(0, 3'b110);
        @(negedge clk);
        async_trig_in = 1'b1;
        idle(4);
        done_pulse();
        socs = 0;
        for (int n = 0; n < 8; n++) begin
            if (soc_out) socs++;
            @(negedge clk);
        end
        rd(2, v);
        check(v == 0 && socs == 0, "R11 no queued trigger", v + socs, 0);

        // R10: done while idle has no effect
        wr(0, 3'b010);
        wr(1, 1);
        rd(2, v); check(v == 1, "R5 armed by start write", v, 1);
        done_pulse();
        rd(2, v); check(v == 1, "R10 idle done ignored", v, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule